// File: doc/BRIEF.md
# Luminance Min-Max Step Sharpener

This block sits in a streaming pixel path and makes large luminance edges steeper. Luma samples move through a five-sample tapped delay line. For every sample the block finds the lowest and highest value in that window. It then outputs one of the two, which replaces a gradual transition with a hard jump at the point where the curvature of the signal changes sign.

The choice is made by a wide second-derivative contour filter with weights -1, 0, 2, 0, -1, taken across the same five taps. A six-bit line-width setting adds a signed bias to the filter result before its sign is tested. This moves the jump earlier or later along an edge, which makes bright features thinner or wider. The block also reports the momentary excursion of the window, maximum minus minimum, for use by later stages.

The chroma components U and V pass through a delay equal to the luma latency, so they leave on the same cycle as the luma sample they belong to. A valid strobe qualifies every input sample. Nothing moves while that strobe is low.

Top module: `luma_step_sharpener`

## Requirements
- R1: On every cycle with `in_valid` high, the newest luma sample enters the five-tap window and every older sample moves one place. When `in_valid` is low, the window, the chroma delay and all outputs hold their values.
- R2: On a valid cycle, the window is the five samples accepted before this one, with tap 0 the most recent and tap 4 the oldest. The output captured on that cycle depends only on this window and on the current `lw_set`.
- R3: The decision value is 2*tap2 - tap0 - tap4 + (`lw_set` - 32), computed as a signed quantity. When the decision value is zero or above, `y_out` takes the window maximum. When it is negative, `y_out` takes the window minimum.
- R4: `env_out` equals the window maximum minus the window minimum, computed for the same window as `y_out`.
- R5: The line-width bias spans -32 (`lw_set` = 000000) to +31 (`lw_set` = 111111). On a straight ramp, where the contour term is zero, `lw_set` = 0 selects the minimum, and `lw_set` of 32 or more selects the maximum.
- R6: `u_out` and `v_out` carry the chroma of the window's centre sample (tap 2), on the same cycle as `y_out`. They are therefore three valid samples late, and no extra delay depends on `lw_set`.
- R7: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. All data outputs change only in those cycles.
- R8: After reset, all taps and the chroma delay hold zero, all outputs are zero, and `out_valid` is low.
- R9: Full-scale patterns, such as 0 and 255 alternating, give a decision value of up to ±510 plus the bias with no wraparound. The selected output stays equal to either the window minimum or the window maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Qualifies the input sample on this cycle |
| y_in | input | YW | Luma sample, unsigned |
| u_in | input | CW | Chroma U sample |
| v_in | input | CW | Chroma V sample |
| lw_set | input | LWW | Line-width setting, mid-code means no bias |
| out_valid | output | 1 | Output sample valid |
| y_out | output | YW | Sharpened luma |
| env_out | output | YW | Window excursion, maximum minus minimum |
| u_out | output | CW | Delayed chroma U |
| v_out | output | CW | Delayed chroma V |

## Verification
The bench builds the block with its default widths: 8-bit luma and chroma and a 6-bit line-width code. With these widths, full-scale 0/255 patterns push the contour term to its ±510 limits. The bias reaches both of its ends, -32 and +31, and the mid-code gives the exact zero-decision tie, where the maximum must win. Rising and falling steps, ramps with each bias extreme, stalled streams with gaps in the valid strobe, and a long pseudo-random run are all compared against a window model kept in the bench.

// File: rtl/luma_step_sharpener.sv
`timescale 1ns/1ps
module luma_step_sharpener #(
  parameter int YW  = 8,
  parameter int CW  = 8,
  parameter int LWW = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [YW-1:0]  y_in,
  input  logic [CW-1:0]  u_in,
  input  logic [CW-1:0]  v_in,
  input  logic [LWW-1:0] lw_set,
  output logic           out_valid,
  output logic [YW-1:0]  y_out,
  output logic [YW-1:0]  env_out,
  output logic [CW-1:0]  u_out,
  output logic [CW-1:0]  v_out
);
  localparam int TAPS   = 5;
  localparam int CTR    = TAPS / 2;
  localparam int CDLY   = CTR + 1;
  localparam int DW     = YW + 3;
  localparam int LW_MID = 1 << (LWW - 1);

  logic [YW-1:0] tap [TAPS];
  logic [CW-1:0] ud  [CDLY];
  logic [CW-1:0] vd  [CDLY];
  logic [YW-1:0] mn, mx;
  logic signed [DW-1:0] ctr, bias, dec;
  logic pick_max;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < TAPS; i++) tap[i] <= '0;
      for (int i = 0; i < CDLY; i++) begin
        ud[i] <= '0;
        vd[i] <= '0;
      end
    end else if (in_valid) begin
      tap[0] <= y_in;
      ud[0]  <= u_in;
      vd[0]  <= v_in;
      for (int i = 1; i < TAPS; i++) tap[i] <= tap[i-1];
      for (int i = 1; i < CDLY; i++) begin
        ud[i] <= ud[i-1];
        vd[i] <= vd[i-1];
      end
    end
  end

  always_comb begin
    mn = tap[0];
    mx = tap[0];
    for (int i = 1; i < TAPS; i++) begin
      if (tap[i] < mn) mn = tap[i];
      if (tap[i] > mx) mx = tap[i];
    end
  end

  assign ctr  = $signed({2'b00, tap[CTR], 1'b0}) - $signed({3'b000, tap[0]})
              - $signed({3'b000, tap[TAPS-1]});
  assign bias = $signed(DW'(lw_set)) - $signed(DW'(LW_MID));
  assign dec  = ctr + bias;
  assign pick_max = !dec[DW-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      y_out     <= '0;
      env_out   <= '0;
      u_out     <= '0;
      v_out     <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        y_out   <= pick_max ? mx : mn;
        env_out <= mx - mn;
        u_out   <= ud[CDLY-1];
        v_out   <= vd[CDLY-1];
      end
    end
  end

  AST_TAP_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> tap[1] == $past(tap[0]));                                  // R1
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(y_out) && $stable(env_out) && $stable(u_out) && $stable(v_out)); // R7
  AST_VALID_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);                                                // R7
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);                                              // R7
  AST_ENVELOPE_PICK: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (y_out == $past(mx)) || (y_out == $past(mn)));             // R9
  AST_FLAT_CENTRE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (mx == mn) |=> y_out == $past(tap[CTR]));                   // R3
endmodule

// File: tb/sim_luma_step_sharpener.sv
`timescale 1ns/1ps
module sim_luma_step_sharpener;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] y_in = '0, u_in = '0, v_in = '0;
  logic [5:0] lw_set = 6'd32;
  logic out_valid;
  logic [7:0] y_out, env_out, u_out, v_out;

  int checks = 0;
  int errors = 0;
  int hy[5], hu[5], hv[5];
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  luma_step_sharpener #(.YW(8), .CW(8), .LWW(6)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .y_in(y_in), .u_in(u_in),
    .v_in(v_in), .lw_set(lw_set), .out_valid(out_valid), .y_out(y_out),
    .env_out(env_out), .u_out(u_out), .v_out(v_out));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_hist();
    for (int i = 0; i < 5; i++) begin hy[i] = 0; hu[i] = 0; hv[i] = 0; end
  endtask

  // drive at a falling edge, check at the next falling edge
  task automatic push(input int y, input int u, input int v, input int lw, input string req);
    int mnv, mxv, d, ey;
    mnv = hy[0]; mxv = hy[0];
    for (int i = 1; i < 5; i++) begin
      if (hy[i] < mnv) mnv = hy[i];
      if (hy[i] > mxv) mxv = hy[i];
    end
    d = 2 * hy[2] - hy[0] - hy[4] + (lw - 32);
    ey = (d >= 0) ? mxv : mnv;
    in_valid = 1'b1; y_in = 8'(y); u_in = 8'(u); v_in = 8'(v); lw_set = 6'(lw);
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " y_out"}, int'(y_out), ey);
    chk("R4 env_out", int'(env_out), mxv - mnv);
    chk("R6 u_out", int'(u_out), hu[2]);
    chk("R6 v_out", int'(v_out), hv[2]);
    chk("R7 out_valid", int'(out_valid), 1);
    for (int i = 4; i > 0; i--) begin hy[i] = hy[i-1]; hu[i] = hu[i-1]; hv[i] = hv[i-1]; end
    hy[0] = y; hu[0] = u; hv[0] = v;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; in_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 out_valid", int'(out_valid), 0);
    chk("R8 y_out", int'(y_out), 0);
    chk("R8 env_out", int'(env_out), 0);
    chk("R8 u_out", int'(u_out), 0);
    rst_n = 1'b1;
    clear_hist();
    @(negedge clk);
    // zeroed taps: first sample sees an all-zero window
    push(90, 1, 2, 32, "R8 zero window");
  endtask

  task automatic t_rise();
    for (int i = 0; i < 5; i++) push(20, 10 + i, 50 + i, 32, "R3 rise flat");
    for (int i = 0; i < 7; i++) push(200, 30 + i, 70 + i, 32, "R3 rise step");
  endtask

  task automatic t_fall();
    for (int i = 0; i < 8; i++) push(30, 5 * i, 255 - i, 32, "R3 fall step");
    for (int i = 0; i < 5; i++) push(180, i, i, 32, "R3 fall flat");
  endtask

  task automatic t_lw();
    for (int i = 0; i < 8; i++) push(10 + 10 * i, i, i, 0, "R5 ramp lw min");
    for (int i = 0; i < 8; i++) push(100 + 10 * i, i, i, 63, "R5 ramp lw max");
    for (int i = 0; i < 6; i++) push(200 + 5 * i, i, i, 32, "R5 ramp lw mid tie");
    push(255, 0, 0, 31, "R5 lw 31");
  endtask

  task automatic t_stall();
    logic [7:0] ys, es, us;
    for (int i = 0; i < 10; i++) begin
      push((i % 3) * 70, i, 2 * i, 20 + i, "R2 stalled stream");
      ys = y_out; es = env_out; us = u_out;
      y_in = 8'hFF; u_in = 8'h55; lw_set = 6'd0;
      repeat (i % 4 + 1) @(negedge clk);
      chk("R7 no valid", int'(out_valid), 0);
      chk("R1 hold y", int'(y_out), int'(ys));
      chk("R1 hold env", int'(env_out), int'(es));
      chk("R1 hold u", int'(u_out), int'(us));
    end
  endtask

  task automatic t_fullscale();
    for (int i = 0; i < 10; i++) push((i % 2) ? 255 : 0, 255, 0, (i % 2) ? 0 : 63, "R9 full scale");
  endtask

  task automatic t_random();
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      push(int'(lfsr[7:0]), int'(lfsr[15:8]), int'(lfsr[11:4]), int'(lfsr[13:8]), "R2 pseudo-random");
    end
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_rise();
    t_fall();
    t_lw();
    t_stall();
    t_fullscale();
    t_random();
    t_reset();
    t_rise();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule